// File: doc/BRIEF.md
# Configuration Address/Data Port Translator

This block sits in a host bridge between a processor's I/O port accesses and the peripheral bus. Software reaches configuration space through two 32-bit ports. One is an address latch that holds an enable flag and a bus/device/function/register address. The other is a data window. When the latched enable flag is set, each access to the data window becomes a configuration read or write at the latched address. In every other case the access goes to the bus unchanged, as an ordinary I/O read or write.

On bus number 0 the block drives a one-hot device-select vector so that the addressed device is the target. A device number with no select line aborts inside the bridge: reads return all ones and writes are dropped. For any other bus number, the request is tagged for forwarding, carries the full address and drives no select line. Accesses to the latch port that are byte or 16-bit wide do not change the latch. They go to the bus as ordinary I/O. Host accesses are held valid until ready. Bus requests use the same level handshake, completed by the bus acknowledge.

Top module: `cfg_port_xlate`

## Requirements
- R1: After reset the address latch reads back as 0x00000000, and its enable flag is clear.
- R2: A write to the latch port with all four byte enables (4'hF) stores the data with bits 30:24 and 1:0 forced to zero. A full read of the latch port returns the stored value. Both accesses finish in the same cycle with h_ready=1 and b_req=0.
- R3: A latch-port access with any byte-enable value other than 4'hF leaves the latch unchanged. It is issued on the bus as an I/O read (b_cmd=0) or I/O write (b_cmd=1) at the latch port address, with the host's byte enables and write data.
- R4: With the enable flag (bit 31) at 0, a data-window access is issued as an I/O read (b_cmd=0) or I/O write (b_cmd=1) at the data port address. Byte enables and write data pass through. h_rdata follows b_rdata, and h_ready follows b_ack.
- R5: With the enable flag at 1, a data-window access is issued as a configuration read (b_cmd=2) or configuration write (b_cmd=3). b_addr is {8'h00, bus[23:16], device[15:11], function[10:8], register[7:2], 2'b00}. The host byte enables pass through unchanged.
- R6: A configuration access to bus 0 whose device number is below NUM_SEL (21) asserts only b_sel[device], with b_fwd=0.
- R7: A configuration access to bus 0 whose device number is NUM_SEL or above makes no bus request and completes in the same cycle. A read returns 0xFFFFFFFF.
- R8: A configuration access to a non-zero bus asserts b_fwd=1 and leaves b_sel all zero.
- R9: An access to any port other than the two parameter ports is an I/O read or write at that port address, with b_sel zero and b_fwd=0, whatever the latch holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host access valid, held until h_ready |
| h_write | input | 1 | Host access is a write |
| h_port | input | PORT_W | Host I/O port address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_ready | output | 1 | Host access completes this cycle |
| h_rdata | output | 32 | Host read data |
| b_req | output | 1 | Bus request valid |
| b_cmd | output | 2 | 0 I/O read, 1 I/O write, 2 config read, 3 config write |
| b_addr | output | 32 | Bus address (port or decoded config address) |
| b_be | output | 4 | Bus byte enables |
| b_wdata | output | 32 | Bus write data |
| b_sel | output | NUM_SEL | One-hot device select for bus-0 config requests |
| b_fwd | output | 1 | Config request targets a non-zero bus |
| b_ack | input | 1 | Bus response valid |
| b_rdata | input | 32 | Bus response data |

## Verification
The hardest case to reach from the ports is a request whose outcome depends on state left behind by an earlier access. The abort path, the forward tag and the unchanged latch after a partial-width write each show up only on a later data-window or latch access. The bench therefore works in pairs: it programs the latch, then touches the data window or reads the latch back. It sweeps every device number on bus 0, including the numbers above the select range, and all sixteen byte-enable values on the latch port. A mid-run reset shows that the enable flag is cleared.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

   typedef enum logic [1:0] {
      CMD_IO_RD  = 2'd0,
      CMD_IO_WR  = 2'd1,
      CMD_CFG_RD = 2'd2,
      CMD_CFG_WR = 2'd3
   } bus_cmd_e;

   typedef struct packed {
      logic       en;
      logic [6:0] rsv_hi;
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] fn;
      logic [5:0] regn;
      logic [1:0] rsv_lo;
   } cfg_addr_t;

   localparam logic [31:0] CFG_WRITABLE = 32'h80FF_FFFC;
   localparam int          DEV_BITS     = 5;

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
   import cfg_xlate_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output cfg_addr_t   q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= cfg_addr_t'(wdata & CFG_WRITABLE);
   end

   // R2: reserved fields never hold a one
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (q.rsv_hi == 7'd0) && (q.rsv_lo == 2'd0));

   // R3: latch holds whenever no full write is taken
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

endmodule

// File: rtl/cfg_sel_decode.sv
module cfg_sel_decode #(
   parameter int NUM_SEL = 21,
   parameter int DEV_W   = 5
) (
   input  logic [DEV_W-1:0]   dev,
   output logic [NUM_SEL-1:0] sel,
   output logic               in_range
);

   if (NUM_SEL < 1 || NUM_SEL > (1 << DEV_W)) begin : g_bad_sel
      $error("cfg_sel_decode: NUM_SEL out of range");
   end

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      assign sel[i] = (dev == DEV_W'(i));
   end

   assign in_range = (int'(dev) < NUM_SEL);

endmodule

// File: rtl/cfg_port_xlate.sv
module cfg_port_xlate
   import cfg_xlate_pkg::*;
#(
   parameter int PORT_W     = 16,
   parameter int LATCH_PORT = 'hCF8,
   parameter int DATA_PORT  = 'hCFC,
   parameter int NUM_SEL    = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               h_valid,
   input  logic               h_write,
   input  logic [PORT_W-1:0]  h_port,
   input  logic [3:0]         h_be,
   input  logic [31:0]        h_wdata,
   output logic               h_ready,
   output logic [31:0]        h_rdata,
   output logic               b_req,
   output logic [1:0]         b_cmd,
   output logic [31:0]        b_addr,
   output logic [3:0]         b_be,
   output logic [31:0]        b_wdata,
   output logic [NUM_SEL-1:0] b_sel,
   output logic               b_fwd,
   input  logic               b_ack,
   input  logic [31:0]        b_rdata
);

   localparam logic [PORT_W-1:0] LP = PORT_W'(LATCH_PORT);
   localparam logic [PORT_W-1:0] DP = PORT_W'(DATA_PORT);

   if (PORT_W < 3 || PORT_W > 32) begin : g_bad_pw
      $error("cfg_port_xlate: PORT_W must be 3..32");
   end
   if (LATCH_PORT == DATA_PORT) begin : g_bad_ports
      $error("cfg_port_xlate: port addresses must differ");
   end

   cfg_addr_t          lat_q;
   logic               lat_we;
   logic [NUM_SEL-1:0] dec_sel;
   logic               dev_ok;

   cfg_addr_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (lat_we),
      .wdata (h_wdata),
      .q     (lat_q)
   );

   cfg_sel_decode #(.NUM_SEL(NUM_SEL), .DEV_W(DEV_BITS)) u_dec (
      .dev      (lat_q.dev),
      .sel      (dec_sel),
      .in_range (dev_ok)
   );

   logic     latch_hit, cfg_hit, local_bus, abort_hit, internal;
   bus_cmd_e cmd;
   logic [31:0] cfg_addr;

   always_comb begin
      latch_hit = (h_port == LP) && (h_be == 4'hF);
      cfg_hit   = (h_port == DP) && lat_q.en;
      local_bus = (lat_q.bus == 8'd0);
      abort_hit = cfg_hit && local_bus && !dev_ok;
      internal  = latch_hit || abort_hit;
      cfg_addr  = {8'h00, lat_q.bus, lat_q.dev, lat_q.fn, lat_q.regn, 2'b00};
      if (cfg_hit)
         cmd = h_write ? CMD_CFG_WR : CMD_CFG_RD;
      else
         cmd = h_write ? CMD_IO_WR : CMD_IO_RD;
   end

   assign lat_we  = h_valid && h_write && latch_hit;
   assign b_req   = h_valid && !internal;
   assign b_cmd   = cmd;
   assign b_addr  = cfg_hit ? cfg_addr : 32'(h_port);
   assign b_be    = h_be;
   assign b_wdata = h_wdata;
   assign b_sel   = (h_valid && cfg_hit && local_bus) ? dec_sel : '0;
   assign b_fwd   = h_valid && cfg_hit && !local_bus;
   assign h_ready = internal ? h_valid : (b_req && b_ack);

   always_comb begin
      if (latch_hit)      h_rdata = 32'(lat_q);
      else if (abort_hit) h_rdata = '1;
      else                h_rdata = b_rdata;
   end

   // R2: full latch-port accesses stay inside the bridge
   a_r2_latch_internal: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && h_port == LP && h_be == 4'hF) |-> (!b_req && h_ready));

   // R7: missing device completes locally, reads all ones
   a_r7_abort_local: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && abort_hit) |-> (!b_req && h_ready && (h_write || h_rdata == 32'hFFFF_FFFF)));

   // R6: at most one select line
   a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(b_sel));

   // R8: forwarded requests drive no select
   a_r8_fwd_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      b_fwd |-> (b_sel == '0));

   // R9: plain I/O never selects or forwards
   a_r9_io_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (b_req && !b_cmd[1]) |-> (b_sel == '0 && !b_fwd));

   // R5: config addresses have reserved bits clear
   a_r5_cfg_addr_form: assert property (@(posedge clk) disable iff (!rst_n)
      (b_req && b_cmd[1]) |-> (b_addr[31:24] == 8'd0 && b_addr[1:0] == 2'd0));

endmodule

// File: tb/tb_cfg_port_xlate.sv
module tb_cfg_port_xlate;

   localparam int NSEL = 21;
   localparam logic [15:0] LPORT = 16'hCF8;
   localparam logic [15:0] DPORT = 16'hCFC;
   localparam logic [31:0] MASK  = 32'h80FF_FFFC;
   localparam logic [31:0] RSP   = 32'hA5A5_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic h_valid = 1'b0, h_write = 1'b0;
   logic [15:0] h_port = '0;
   logic [3:0]  h_be = '0;
   logic [31:0] h_wdata = '0;
   logic        h_ready;
   logic [31:0] h_rdata;
   logic        b_req;
   logic [1:0]  b_cmd;
   logic [31:0] b_addr, b_wdata, b_rdata;
   logic [3:0]  b_be;
   logic [NSEL-1:0] b_sel;
   logic        b_fwd, b_ack;

   always #10 clk = ~clk;

   assign b_ack   = b_req;
   assign b_rdata = b_addr ^ RSP;

   cfg_port_xlate dut (
      .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_write(h_write),
      .h_port(h_port), .h_be(h_be), .h_wdata(h_wdata), .h_ready(h_ready),
      .h_rdata(h_rdata), .b_req(b_req), .b_cmd(b_cmd), .b_addr(b_addr),
      .b_be(b_be), .b_wdata(b_wdata), .b_sel(b_sel), .b_fwd(b_fwd),
      .b_ack(b_ack), .b_rdata(b_rdata)
   );

   int n_run = 0, n_fail = 0;
   logic        s_req, s_ready, s_fwd;
   logic [1:0]  s_cmd;
   logic [31:0] s_addr, s_wdata, s_rdata, s_sel;
   logic [3:0]  s_be;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic wr, input logic [15:0] port, input logic [3:0] be,
                      input logic [31:0] wd);
      h_valid = 1'b1; h_write = wr; h_port = port; h_be = be; h_wdata = wd;
      #2;
      s_req = b_req; s_ready = h_ready; s_fwd = b_fwd; s_cmd = b_cmd;
      s_addr = b_addr; s_wdata = b_wdata; s_rdata = h_rdata; s_be = b_be;
      s_sel = 32'(b_sel);
      @(negedge clk);
      h_valid = 1'b0; h_write = 1'b0;
   endtask

   task automatic read_latch(input string req, input logic [31:0] exp);
      acc(1'b0, LPORT, 4'hF, 32'h0);
      chk(req, s_rdata, exp);
      chk(req, {31'd0, s_req}, 32'd0);
      chk(req, {31'd0, s_ready}, 32'd1);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] cur;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      read_latch("R1", 32'h0);

      // R2/R3: sweep byte enables on the latch port
      cur = 32'h0;
      for (int be = 0; be < 16; be++) begin
         logic [31:0] wd;
         wd = 32'hFFFF_FFFF ^ (32'(be) * 32'h0101_1357);
         acc(1'b1, LPORT, 4'(be), wd);
         if (be == 15) begin
            cur = wd & MASK;
            chk("R2", {31'd0, s_req}, 32'd0);
            chk("R2", {31'd0, s_ready}, 32'd1);
         end else begin
            chk("R3", {31'd0, s_req}, 32'd1);
            chk("R3", {30'd0, s_cmd}, 32'd1);
            chk("R3", s_addr, 32'(LPORT));
            chk("R3", {28'd0, s_be}, 32'(be));
            chk("R3", s_wdata, wd);
         end
         read_latch(be == 15 ? "R2" : "R3", cur);
      end
      acc(1'b0, LPORT, 4'h3, 32'h0);
      chk("R3", {30'd0, s_cmd}, 32'd0);
      chk("R3", s_rdata, 32'(LPORT) ^ RSP);

      // R4: enable clear -> plain I/O on the data window
      acc(1'b1, LPORT, 4'hF, 32'h7F00_1234);
      read_latch("R2", 32'h0000_1234);
      acc(1'b0, DPORT, 4'hF, 32'h0);
      chk("R4", {30'd0, s_cmd}, 32'd0);
      chk("R4", s_addr, 32'(DPORT));
      chk("R4", s_rdata, 32'(DPORT) ^ RSP);
      chk("R4", {31'd0, s_ready}, 32'd1);
      acc(1'b1, DPORT, 4'b0110, 32'hDEAD_BEEF);
      chk("R4", {30'd0, s_cmd}, 32'd1);
      chk("R4", {28'd0, s_be}, 32'h6);
      chk("R4", s_wdata, 32'hDEAD_BEEF);
      chk("R4", s_sel, 32'd0);

      // R5/R6/R7: every device number on bus 0
      for (int d = 0; d < 32; d++) begin
         logic [31:0] wd, ea;
         wd = {1'b1, 7'h7F, 8'h00, 5'(d), 3'(d), 6'(d + 9), 2'b11};
         ea = {8'h00, 8'h00, 5'(d), 3'(d), 6'(d + 9), 2'b00};
         acc(1'b1, LPORT, 4'hF, wd);
         acc(1'b0, DPORT, 4'hA, 32'h0);
         if (d < NSEL) begin
            chk("R5", {30'd0, s_cmd}, 32'd2);
            chk("R5", s_addr, ea);
            chk("R5", {28'd0, s_be}, 32'hA);
            chk("R6", s_sel, 32'd1 << d);
            chk("R6", {31'd0, s_fwd}, 32'd0);
            chk("R5", s_rdata, ea ^ RSP);
         end else begin
            chk("R7", {31'd0, s_req}, 32'd0);
            chk("R7", {31'd0, s_ready}, 32'd1);
            chk("R7", s_rdata, 32'hFFFF_FFFF);
            chk("R7", s_sel, 32'd0);
            acc(1'b1, DPORT, 4'hF, 32'h1234_5678);
            chk("R7", {31'd0, s_req}, 32'd0);
            chk("R7", {31'd0, s_ready}, 32'd1);
         end
      end

      // R8: non-zero buses forward
      for (int k = 0; k < 4; k++) begin
         logic [7:0] bn;
         logic [31:0] ea;
         bn = (k == 0) ? 8'h01 : (k == 1) ? 8'h02 : (k == 2) ? 8'h80 : 8'hFF;
         ea = {8'h00, bn, 5'd31, 3'd7, 6'h3F, 2'b00};
         acc(1'b1, LPORT, 4'hF, {1'b1, 7'h00, bn, 5'd31, 3'd7, 6'h3F, 2'b00});
         acc(1'b1, DPORT, 4'h5, 32'hCAFE_0000 + 32'(k));
         chk("R8", {31'd0, s_fwd}, 32'd1);
         chk("R8", s_sel, 32'd0);
         chk("R5", {30'd0, s_cmd}, 32'd3);
         chk("R5", s_addr, ea);
         chk("R5", s_wdata, 32'hCAFE_0000 + 32'(k));
         chk("R5", {28'd0, s_be}, 32'h5);
      end

      // R9: other ports with enable set
      acc(1'b1, LPORT, 4'hF, 32'h8000_0800);
      acc(1'b0, 16'h0080, 4'hF, 32'h0);
      chk("R9", {30'd0, s_cmd}, 32'd0);
      chk("R9", s_addr, 32'h80);
      chk("R9", s_sel, 32'd0);
      acc(1'b1, 16'hCF9, 4'h1, 32'h55);
      chk("R9", {30'd0, s_cmd}, 32'd1);
      chk("R9", s_addr, 32'hCF9);
      chk("R9", {31'd0, s_fwd}, 32'd0);

      // R1: mid-run reset clears the enable
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_latch("R1", 32'h0);
      acc(1'b0, DPORT, 4'hF, 32'h0);
      chk("R1", {30'd0, s_cmd}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule